// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the control pins of a single-data-rate SDRAM from the moment reset is released until the memory can accept traffic. It first waits a start-up pause, with the clock enable and every data mask line held high and only NOP commands on the bus. It then precharges all banks, writes the mode register, and issues a run of auto refresh commands. Every command is followed by a configurable number of NOP clocks. When the last refresh gap has elapsed, it raises a done flag, drops the data masks and keeps issuing NOPs until the next reset.

The pause length in clocks is worked out from the clock frequency in MHz and the pause in microseconds. The mode register word is assembled from burst length, wrap order, CAS latency and write-burst options. All of these are parameters, and elaboration checks reject illegal values. A controller places this block in front of its normal command path and switches over once `done` is high.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted the outputs show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), address 0, bank 0, CKE high, every DQM bit high and done low.
- R2: For the first CLK_MHZ*PAUSE_US cycles after reset release only NOP is driven, with every DQM bit high; DQM stays all-ones for as long as done is low.
- R3: The first command after the pause is precharge-all: pins 0010, address bit AP_BIT high, all other address bits and the bank bits zero.
- R4: Exactly NOP_RP NOP cycles follow the precharge, then a mode register set (pins 0000, bank 0) whose address carries the burst length code in bits 2:0 (1,2,4,8 give 0,1,2,3), the interleave flag in bit 3, the CAS latency (2 or 3) in bits 6:4 and the single-write flag in bit 9. No refresh comes before it.
- R5: Exactly NOP_MRD NOP cycles (at least one) follow the mode register set before the next command.
- R6: REFRESH_N auto refresh commands (pins 0001, address and bank zero, REFRESH_N at least 8) follow, each followed by exactly NOP_RC NOP cycles. No two commands are ever issued back to back.
- R7: CKE is high in every cycle, including the cycle before the mode register set.
- R8: In the cycle after the last refresh gap, done goes high and DQM goes all-zero. From then on done stays high and only NOP is driven.
- R9: Asserting reset at any point aborts the sequence; after release the whole sequence restarts from the pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | SDRAM clock enable |
| dqm | output | DQM_W | Data mask lines, all high until done |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins (precharge-all flag, mode word) |
| ba | output | BA_W | Bank address, always zero here |
| done | output | 1 | Initialization complete, sticky until reset |

## Verification
Two events can land on the same clock edge. One is the expiry of the last refresh gap, which raises done and drops the masks. The other is an external reset arriving in the middle of the sequence, which must win over any command step that is due. The bench first runs the full sequence and checks that done and the DQM release appear together in exactly the cycle after the final NOP_RC gap. It then asserts reset shortly after the precharge, while a gap countdown is under way, and checks that the outputs fall straight back to the reset pattern. Finally it checks that a fresh run matches the behavioural reference cycle for cycle, starting again from the pause.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_PAUSE,
      ST_PRE,
      ST_GAP_RP,
      ST_MRS,
      ST_GAP_MRD,
      ST_REF,
      ST_GAP_RC,
      ST_READY
   } init_st_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic [2:0] bl_code(input int bl);
      case (bl)
         1:       return 3'd0;
         2:       return 3'd1;
         4:       return 3'd2;
         default: return 3'd3;
      endcase
   endfunction

   // Mode register word; bit positions are decoded by the memory device.
   function automatic logic [15:0] mode_word(input int bl, input int ilv,
                                             input int cl, input int single_wr);
      logic [15:0] w;
      w        = '0;
      w[2:0]   = bl_code(bl);
      w[3]     = (ilv != 0);
      w[6:4]   = 3'(cl);
      w[9]     = (single_wr != 0);
      return w;
   endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int CNT_W   = 16,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(RST_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
   import sdram_init_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2,
   parameter int AP_BIT = 10
) (
   input  init_st_e          state,
   input  logic [ADDR_W-1:0] mode_val,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba
);

   sd_cmd_e cmd;

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      ba   = '0;
      case (state)
         ST_PRE: begin
            cmd          = CMD_PRE;
            addr[AP_BIT] = 1'b1;
         end
         ST_MRS: begin
            cmd  = CMD_MRS;
            addr = mode_val;
         end
         ST_REF:  cmd = CMD_REF;
         default: cmd = CMD_NOP;
      endcase
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_init_pkg::*;
#(
   parameter int CLK_MHZ      = 166,
   parameter int PAUSE_US     = 200,
   parameter int NOP_RP       = 3,
   parameter int NOP_MRD      = 2,
   parameter int NOP_RC       = 10,
   parameter int REFRESH_N    = 8,
   parameter int BURST_LEN    = 4,
   parameter int INTERLEAVE   = 0,
   parameter int CAS_LAT      = 3,
   parameter int SINGLE_WRITE = 0,
   parameter int ADDR_W       = 13,
   parameter int BA_W         = 2,
   parameter int DQM_W        = 2,
   parameter int AP_BIT       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cke,
   output logic [DQM_W-1:0]  dqm,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              done
);

   localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
   localparam int MAX_LOAD  = imax(imax(PAUSE_CYC, NOP_RP), imax(NOP_MRD, NOP_RC));
   localparam int CNT_W     = $clog2(MAX_LOAD + 1);
   localparam int REF_W     = $clog2(REFRESH_N + 1);
   localparam logic [15:0] MODE16 = mode_word(BURST_LEN, INTERLEAVE, CAS_LAT, SINGLE_WRITE);
   localparam logic [ADDR_W-1:0] MODE_VAL = MODE16[ADDR_W-1:0];

   // elaboration-time parameter checks
   if (PAUSE_CYC < 1) begin : g_bad_pause
      $error("pause must be at least one clock");
   end
   if (NOP_RP < 1 || NOP_MRD < 1 || NOP_RC < 1) begin : g_bad_gap
      $error("every command needs at least one trailing NOP");
   end
   if (REFRESH_N < 8) begin : g_bad_ref
      $error("at least eight refresh commands are required");
   end
   if (!(BURST_LEN == 1 || BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
      $error("burst length must be 1, 2, 4 or 8");
   end
   if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_cl
      $error("CAS latency must be 2 or 3");
   end
   if (ADDR_W < 11 || ADDR_W > 16 || AP_BIT >= ADDR_W || AP_BIT < 10) begin : g_bad_addr
      $error("address width must hold the mode word and the precharge-all bit");
   end
   if (DQM_W < 1 || BA_W < 1) begin : g_bad_w
      $error("mask and bank widths must be positive");
   end

   init_st_e         state_q, state_d;
   logic             tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;
   logic [REF_W-1:0] ref_q;
   logic             last_ref;

   sdram_init_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (PAUSE_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   // refresh counter: width chosen so REFRESH_N itself is representable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
      end else if (state_q == ST_REF) begin
         ref_q <= ref_q + 1'b1;
      end
   end

   assign last_ref = (ref_q == REF_W'(REFRESH_N));

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_PAUSE:   if (tmr_done) state_d = ST_PRE;
         ST_PRE: begin
            state_d  = ST_GAP_RP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(NOP_RP - 1);
         end
         ST_GAP_RP:  if (tmr_done) state_d = ST_MRS;
         ST_MRS: begin
            state_d  = ST_GAP_MRD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(NOP_MRD - 1);
         end
         ST_GAP_MRD: if (tmr_done) state_d = ST_REF;
         ST_REF: begin
            state_d  = ST_GAP_RC;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(NOP_RC - 1);
         end
         ST_GAP_RC:  if (tmr_done) state_d = last_ref ? ST_READY : ST_REF;
         default:    state_d = ST_READY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PAUSE;
      end else begin
         state_q <= state_d;
      end
   end

   sdram_init_cmd_enc #(
      .ADDR_W (ADDR_W),
      .BA_W   (BA_W),
      .AP_BIT (AP_BIT)
   ) u_enc (
      .state    (state_q),
      .mode_val (MODE_VAL),
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .addr     (addr),
      .ba       (ba)
   );

   assign done = (state_q == ST_READY);
   assign dqm  = done ? '0 : '1;
   assign cke  = 1'b1;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
   parameter int PAUSE_CYC = 1,
   parameter int REFRESH_N = 8,
   parameter int ADDR_W    = 13,
   parameter int BA_W      = 2,
   parameter int DQM_W     = 2,
   parameter int AP_BIT    = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic [DQM_W-1:0]  dqm,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic [BA_W-1:0]   ba,
   input logic              done
);

   logic [3:0] pins;
   logic       is_nop, is_pre, is_mrs, is_ref;
   int unsigned cyc_q;
   int unsigned refs_q;
   logic        mrs_seen_q;

   assign pins   = {cs_n, ras_n, cas_n, we_n};
   assign is_nop = (pins == 4'b0111);
   assign is_pre = (pins == 4'b0010);
   assign is_mrs = (pins == 4'b0000);
   assign is_ref = (pins == 4'b0001);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q      <= 0;
         refs_q     <= 0;
         mrs_seen_q <= 1'b0;
      end else begin
         if (cyc_q != 32'hFFFF_FFFF) cyc_q <= cyc_q + 1;
         if (is_ref) refs_q <= refs_q + 1;
         if (is_mrs) mrs_seen_q <= 1'b1;
      end
   end

   AST_PAUSE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      !is_nop |-> cyc_q >= PAUSE_CYC);                                    // R2
   AST_MASK_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (dqm == {DQM_W{1'b1}}));                                  // R2
   AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> addr[AP_BIT]);                                           // R3
   AST_MRS_BEFORE_REF: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> mrs_seen_q);                                             // R4
   AST_MRS_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |=> is_nop);                                                 // R5
   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      !is_nop |=> is_nop);                                                // R6
   AST_REF_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> refs_q == REFRESH_N);                               // R6
   AST_CKE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      cke);                                                               // R7
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);                                                     // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (is_nop && dqm == '0 && ba == '0));                        // R8

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
   .PAUSE_CYC (PAUSE_CYC),
   .REFRESH_N (REFRESH_N),
   .ADDR_W    (ADDR_W),
   .BA_W      (BA_W),
   .DQM_W     (DQM_W),
   .AP_BIT    (AP_BIT)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cke   (cke),
   .dqm   (dqm),
   .cs_n  (cs_n),
   .ras_n (ras_n),
   .cas_n (cas_n),
   .we_n  (we_n),
   .addr  (addr),
   .ba    (ba),
   .done  (done)
);

// File: tb/sdram_pwrup_seq_test.sv
module sdram_pwrup_seq_test;

   localparam int CLK_MHZ = 250;
   localparam int PAUSE_US = 2;
   localparam int NRP = 3;
   localparam int NMRD = 2;
   localparam int NRC = 7;
   localparam int NREF = 8;
   localparam int AW = 13;
   localparam int BW = 2;
   localparam int DW = 2;
   localparam int PAUSE = CLK_MHZ * PAUSE_US;
   // BL=8 -> 3, interleave -> bit3, CL=2 -> 010 in 6:4, single write -> bit9
   localparam logic [AW-1:0] MODE_EXP = 13'h22B;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke, cs_n, ras_n, cas_n, we_n, done;
   logic [DW-1:0] dqm;
   logic [AW-1:0] addr;
   logic [BW-1:0] ba;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sdram_pwrup_seq #(
      .CLK_MHZ (CLK_MHZ), .PAUSE_US (PAUSE_US), .NOP_RP (NRP),
      .NOP_MRD (NMRD), .NOP_RC (NRC), .REFRESH_N (NREF),
      .BURST_LEN (8), .INTERLEAVE (1), .CAS_LAT (2), .SINGLE_WRITE (1),
      .ADDR_W (AW), .BA_W (BW), .DQM_W (DW), .AP_BIT (10)
   ) uut (
      .clk (clk), .rst_n (rst_n), .cke (cke), .dqm (dqm),
      .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
      .addr (addr), .ba (ba), .done (done)
   );

   // reference schedule, one entry per cycle after reset release
   logic [3:0]    q_cmd[$];
   logic [AW-1:0] q_addr[$];
   logic          q_done[$];
   string         q_tag[$];

   task automatic push(input logic [3:0] c, input logic [AW-1:0] a,
                       input logic d, input string t);
      q_cmd.push_back(c);
      q_addr.push_back(a);
      q_done.push_back(d);
      q_tag.push_back(t);
   endtask

   task automatic build_schedule();
      q_cmd.delete(); q_addr.delete(); q_done.delete(); q_tag.delete();
      for (int i = 0; i < PAUSE; i++) push(4'b0111, '0, 1'b0, "R2");
      push(4'b0010, 13'h400, 1'b0, "R3");
      for (int i = 0; i < NRP; i++) push(4'b0111, '0, 1'b0, "R4");
      push(4'b0000, MODE_EXP, 1'b0, "R4");
      for (int i = 0; i < NMRD; i++) push(4'b0111, '0, 1'b0, "R5");
      for (int r = 0; r < NREF; r++) begin
         push(4'b0001, '0, 1'b0, "R6");
         for (int i = 0; i < NRC; i++) push(4'b0111, '0, 1'b0, "R6");
      end
      for (int i = 0; i < 25; i++) push(4'b0111, '0, 1'b1, "R8");
   endtask

   task automatic chk(input string tag, input string what,
                      input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic check_reset_state();
      chk("R1", "pins", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
      chk("R1", "addr", int'(addr), 0);
      chk("R1", "ba", int'(ba), 0);
      chk("R1", "cke", int'(cke), 1);
      chk("R1", "dqm", int'(dqm), 3);
      chk("R1", "done", int'(done), 0);
   endtask

   // compare the first n schedule entries, one per cycle
   task automatic run_compare(input int n, input string pfx);
      for (int k = 0; k < n; k++) begin
         string t;
         t = (pfx == "") ? q_tag[k] : pfx;
         chk(t, "pins", int'({cs_n, ras_n, cas_n, we_n}), int'(q_cmd[k]));
         chk(t, "addr", int'(addr), int'(q_addr[k]));
         chk(t, "ba", int'(ba), 0);
         chk(t, "done", int'(done), int'(q_done[k]));
         chk(t, "dqm", int'(dqm), q_done[k] ? 0 : 3);
         chk("R7", "cke", int'(cke), 1);
         @(negedge clk);
         #1;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      build_schedule();
      repeat (3) @(negedge clk);
      #1;
      check_reset_state();                      // R1
      rst_n = 1'b1;
      #1;
      run_compare(q_cmd.size(), "");            // R2..R8 full sequence
      // R9: abort during the post-precharge gap, then restart
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_reset_state();                      // R1 after abort
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      run_compare(PAUSE + 2, "R9");
      rst_n = 1'b0;
      #1;
      chk("R9", "pins after abort", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
      chk("R9", "done after abort", int'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      run_compare(q_cmd.size(), "R9");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule